// File: doc/BRIEF.md
# Shared-Bus Three-Register Transfer Datapath

This block holds three registers of equal width that exchange data over one shared bus. A single 3-to-1 multiplexer drives the bus. A two-bit source code picks which register drives it. Each register has its own load enable. On a clock edge, every enabled register captures whatever is on the bus. One source can therefore feed any subset of destinations in a cycle. Two different sources can never be moved in the same cycle.

A separate preload port writes a chosen register directly. The surrounding logic or a testbench uses it to set up operands. The bus value is brought out so that the current transfer can be observed.

The datapath has no sequencing of its own. The "states" are simply the three register contents. The only transitions are:
- reset, which clears all three registers;
- a bus load, which captures the bus;
- a preload, which writes the preload data;
- a hold, which keeps the value.

Top module: `xfer_bus_top`

## Requirements
- R1: Source code 00 drives register 0 onto the bus, 01 drives register 1, and 10 drives register 2. The bus follows the selected register in the same cycle, with no clock delay.
- R2: Source code 11 drives all zeros onto the bus. Any register loaded in that cycle captures zero.
- R3: A register whose load enable is high takes the bus value at the next rising clock edge. Load enable bit i belongs to register i.
- R4: A register whose load enable is low, and which is not being preloaded, keeps its value across the clock edge.
- R5: One source may be loaded into two or more destinations at the same clock edge. For example, source 10 with load bits 0 and 1 set copies register 2 into both register 0 and register 1.
- R6: Loading a register from itself leaves its value unchanged. For example, source 10 with load bit 2 set leaves register 2 as it was.
- R7: In one cycle only the selected source moves. An attempted exchange of registers 0 and 1 with source 00 and load bits 0 and 1 gives register 1 the old register 0 value, and register 0 keeps its own value. A true exchange therefore takes more than one clock.
- R8: When the preload enable is high and the preload index is 0, 1 or 2, the indexed register takes the preload data at the next edge. This overrides its load enable. Index 11 writes nothing, and the other registers still follow their load enables.
- R9: An active-low reset, applied asynchronously, clears all three registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 2 | Bus source code (00/01/10 = register 0/1/2, 11 = zero) |
| load_en | input | 3 | Per-register bus load enables, bit i for register i |
| pre_we | input | 1 | Preload write enable |
| pre_idx | input | 2 | Preload target register index (11 = none) |
| pre_data | input | W | Preload data |
| reg0_q | output | W | Register 0 contents |
| reg1_q | output | W | Register 1 contents |
| reg2_q | output | W | Register 2 contents |
| bus_q | output | W | Current bus value |

## Verification
The registers are first preloaded with distinct values, so that every source code produces a bus value that can be told apart from the others.

Directed cases cover:
- a single-destination copy;
- a broadcast to two destinations;
- a self-load;
- a zero-source load;
- an attempted one-cycle exchange, which shows that only one source moves.

A sweep then runs every source code against every load-enable pattern and compares the results with a model in the bench. This separates a wrong mux leg from a wrong enable mapping.

Preload collisions with bus loads, and the unused preload index, show whether the preload takes priority and whether the other registers stay independent of it.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
    localparam int NUM_REGS = 3;
    localparam int SEL_W    = 2;

    typedef enum logic [SEL_W-1:0] {
        SRC_R0   = 2'b00,
        SRC_R1   = 2'b01,
        SRC_R2   = 2'b10,
        SRC_ZERO = 2'b11
    } src_e;
endpackage

// File: rtl/xfer_bus_mux.sv
module xfer_bus_mux
    import xfer_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [SEL_W-1:0]           sel,
    input  logic [NUM_REGS-1:0][W-1:0] regs,
    output logic [W-1:0]               bus
);
    src_e code;
    assign code = src_e'(sel);

    always_comb begin
        unique case (code)
            SRC_R0:   bus = regs[0];
            SRC_R1:   bus = regs[1];
            SRC_R2:   bus = regs[2];
            SRC_ZERO: bus = '0;
            default:  bus = '0;
        endcase
    end
endmodule

// File: rtl/xfer_reg_slot.sv
module xfer_reg_slot #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         pre_hit,
    input  logic [W-1:0] bus,
    input  logic [W-1:0] pre_data,
    output logic [W-1:0] q
);
    logic [W-1:0] q_next;

    // Preload wins over a bus load; otherwise hold.
    always_comb begin
        if (pre_hit)
            q_next = pre_data;
        else if (load)
            q_next = bus;
        else
            q_next = q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else
            q <= q_next;
    end
endmodule

// File: rtl/xfer_bus_top.sv
module xfer_bus_top
    import xfer_pkg::*;
#(
    parameter int W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       src_sel,
    input  logic [2:0]       load_en,
    input  logic             pre_we,
    input  logic [1:0]       pre_idx,
    input  logic [W-1:0]     pre_data,
    output logic [W-1:0]     reg0_q,
    output logic [W-1:0]     reg1_q,
    output logic [W-1:0]     reg2_q,
    output logic [W-1:0]     bus_q
);
    logic [NUM_REGS-1:0][W-1:0] regs;
    logic [W-1:0]               bus;

    xfer_bus_mux #(.W(W)) u_mux (
        .sel  (src_sel),
        .regs (regs),
        .bus  (bus)
    );

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
        logic hit;
        assign hit = pre_we && (pre_idx == SEL_W'(i));

        xfer_reg_slot #(.W(W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load_en[i]),
            .pre_hit  (hit),
            .bus      (bus),
            .pre_data (pre_data),
            .q        (regs[i])
        );
    end

    assign reg0_q = regs[0];
    assign reg1_q = regs[1];
    assign reg2_q = regs[2];
    assign bus_q  = bus;
endmodule

// File: rtl/xfer_bus_chk.sv
module xfer_bus_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic [1:0]   src_sel,
    input logic [2:0]   load_en,
    input logic         pre_we,
    input logic [1:0]   pre_idx,
    input logic [W-1:0] reg0_q,
    input logic [W-1:0] reg1_q,
    input logic [W-1:0] reg2_q,
    input logic [W-1:0] bus_q
);
    a_r1_bus_r0: assert property (@(posedge clk) disable iff (!rst_n)
        src_sel == 2'b00 |-> bus_q == reg0_q);
    a_r1_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
        src_sel == 2'b10 |-> bus_q == reg2_q);
    a_r2_zero_bus: assert property (@(posedge clk) disable iff (!rst_n)
        src_sel == 2'b11 |-> bus_q == '0);
    a_r3_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en[1] && !(pre_we && pre_idx == 2'b01)) |=> reg1_q == $past(bus_q));
    a_r4_hold_r0: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en[0] && !(pre_we && pre_idx == 2'b00)) |=> $stable(reg0_q));
    a_r6_self_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == 2'b10 && !(pre_we && pre_idx == 2'b10)) |=> $stable(reg2_q));
endmodule

bind xfer_bus_top xfer_bus_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_sel (src_sel),
    .load_en (load_en),
    .pre_we  (pre_we),
    .pre_idx (pre_idx),
    .reg0_q  (reg0_q),
    .reg1_q  (reg1_q),
    .reg2_q  (reg2_q),
    .bus_q   (bus_q)
);

// File: tb/xfer_bus_top_test.sv
`timescale 1ns/1ps
module xfer_bus_top_test;
    localparam int W = 4;

    logic         clk = 0;
    logic         rst_n = 0;
    logic [1:0]   src_sel = 0;
    logic [2:0]   load_en = 0;
    logic         pre_we = 0;
    logic [1:0]   pre_idx = 0;
    logic [W-1:0] pre_data = 0;
    logic [W-1:0] reg0_q, reg1_q, reg2_q, bus_q;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    xfer_bus_top #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .load_en(load_en),
        .pre_we(pre_we), .pre_idx(pre_idx), .pre_data(pre_data),
        .reg0_q(reg0_q), .reg1_q(reg1_q), .reg2_q(reg2_q), .bus_q(bus_q)
    );

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive at negedge, apply one posedge, sample 1 ns after it.
    task automatic cyc(logic [1:0] s, logic [2:0] l, logic we, logic [1:0] idx, logic [W-1:0] d);
        @(negedge clk);
        src_sel = s; load_en = l; pre_we = we; pre_idx = idx; pre_data = d;
        @(posedge clk);
        #1;
        src_sel = 2'b11; load_en = 0; pre_we = 0;
    endtask

    task automatic preload3(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
        cyc(2'b11, 3'b000, 1'b1, 2'd0, a);
        cyc(2'b11, 3'b000, 1'b1, 2'd1, b);
        cyc(2'b11, 3'b000, 1'b1, 2'd2, c);
    endtask

    task automatic t_reset;
        check("R9 reg0", reg0_q, 0);
        check("R9 reg1", reg1_q, 0);
        check("R9 reg2", reg2_q, 0);
    endtask

    task automatic t_bus_select;
        preload3(4'h3, 4'h9, 4'hC);
        check("R8 preload reg0", reg0_q, 4'h3);
        check("R8 preload reg1", reg1_q, 4'h9);
        check("R8 preload reg2", reg2_q, 4'hC);
        @(negedge clk);
        src_sel = 2'b00; #0.5; check("R1 sel00", bus_q, 4'h3);
        src_sel = 2'b01; #0.5; check("R1 sel01", bus_q, 4'h9);
        src_sel = 2'b10; #0.5; check("R1 sel10", bus_q, 4'hC);
        src_sel = 2'b11; #0.5; check("R2 sel11 bus", bus_q, 4'h0);
    endtask

    task automatic t_single_copy;
        preload3(4'h5, 4'h6, 4'hA);
        cyc(2'b00, 3'b100, 0, 0, 0);
        check("R3 reg2<-reg0", reg2_q, 4'h5);
        check("R4 reg1 held", reg1_q, 4'h6);
        check("R4 reg0 held", reg0_q, 4'h5);
    endtask

    task automatic t_broadcast;
        preload3(4'h1, 4'h2, 4'hE);
        cyc(2'b10, 3'b011, 0, 0, 0);
        check("R5 reg0<-reg2", reg0_q, 4'hE);
        check("R5 reg1<-reg2", reg1_q, 4'hE);
        check("R5 reg2 kept", reg2_q, 4'hE);
    endtask

    task automatic t_self_load;
        preload3(4'h4, 4'h7, 4'hB);
        cyc(2'b10, 3'b110, 0, 0, 0);
        check("R6 reg2 self", reg2_q, 4'hB);
        check("R3 reg1<-reg2", reg1_q, 4'hB);
    endtask

    task automatic t_zero_load;
        preload3(4'hF, 4'hF, 4'hF);
        cyc(2'b11, 3'b101, 0, 0, 0);
        check("R2 reg0 zero", reg0_q, 4'h0);
        check("R2 reg2 zero", reg2_q, 4'h0);
        check("R4 reg1 held", reg1_q, 4'hF);
    endtask

    task automatic t_swap_attempt;
        preload3(4'h8, 4'hD, 4'h2);
        cyc(2'b00, 3'b011, 0, 0, 0);
        check("R7 reg1 got reg0", reg1_q, 4'h8);
        check("R7 reg0 not reg1", reg0_q, 4'h8);
    endtask

    task automatic t_preload_prio;
        preload3(4'h1, 4'h2, 4'h3);
        cyc(2'b10, 3'b011, 1'b1, 2'd0, 4'h9);
        check("R8 preload beats load", reg0_q, 4'h9);
        check("R8 other still loads", reg1_q, 4'h3);
        cyc(2'b11, 3'b000, 1'b1, 2'd3, 4'h6);
        check("R8 idx11 reg0", reg0_q, 4'h9);
        check("R8 idx11 reg1", reg1_q, 4'h3);
        check("R8 idx11 reg2", reg2_q, 4'h3);
    endtask

    task automatic t_sweep;
        logic [W-1:0] m [3];
        logic [W-1:0] b;
        for (int s = 0; s < 4; s++) begin
            for (int l = 0; l < 8; l++) begin
                m[0] = W'(s * 3 + 1); m[1] = W'(l + 5); m[2] = W'(s + l * 2 + 7);
                preload3(m[0], m[1], m[2]);
                b = (s == 3) ? '0 : m[s];
                for (int k = 0; k < 3; k++)
                    if (l[k]) m[k] = b;
                cyc(2'(s), 3'(l), 0, 0, 0);
                check("R3 sweep reg0", reg0_q, m[0]);
                check("R4 sweep reg1", reg1_q, m[1]);
                check("R1 sweep reg2", reg2_q, m[2]);
            end
        end
    endtask

    task automatic t_async_reset;
        preload3(4'h7, 4'h7, 4'h7);
        @(negedge clk);
        #0.5 rst_n = 0;
        #0.5;
        check("R9 async reg0", reg0_q, 0);
        check("R9 async reg2", reg2_q, 0);
        @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        src_sel = 2'b11;
        repeat (3) @(posedge clk);
        #1 t_reset();
        @(negedge clk) rst_n = 1;
        t_bus_select();
        t_single_copy();
        t_broadcast();
        t_self_load();
        t_zero_load();
        t_swap_attempt();
        t_preload_prio();
        t_sweep();
        t_async_reset();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule